// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block supervises a working memory that has a shadow nonvolatile copy. It decides when the working contents are saved to the shadow array (a store) and when the shadow array is loaded back into the working memory (a recall). It also gates the host's reads and writes around both operations. Its inputs are two supply comparators: one says the supply is above the switch level and the other says it is above the reset level. It also watches an enable for stores on power loss and a shared active-low request pin. It drives that same pin low as an open-drain busy signal.

A store runs only if a write has been accepted since the last store or recall. Both store and recall are carried out as ascending word-by-word transfer strobes on an internal copy port. The memory wrapper performs the actual data movement. Every duration is a parameter counted in clock cycles: grace delay, store window, recall window, recovery delay and pin-probe window.

Top module: `nvstore_ctrl`

## Requirements
- R1: After reset, once `vsw_ok` is high, a recall runs for RECALL_CYC cycles. During it `rd_en` is low. `xfer_en` pulses exactly 2^ADDR_W times with `xfer_to_nv` = 0 and addresses 0, 1, 2, … in consecutive cycles, and the pin is not pulled low.
- R2: In the ready state with `vsw_ok` high, `wr_grant` equals `wr_req` in the same cycle. A granted write marks the memory modified.
- R3: A low level on `req_pin_in` seen in the ready state with the memory modified starts a grace window of GRACE_CYC cycles. In that window reads stay enabled and writes are refused. A store window of STORE_CYC cycles follows, during which `xfer_en` pulses 2^ADDR_W times with `xfer_to_nv` = 1. `req_pull_low` is high for GRACE_CYC+STORE_CYC cycles in total.
- R4: A low level on `req_pin_in` with the memory unmodified performs no store and no pull. It still disables access.
- R5: After a pin request, access stays disabled while the pin is low. Once the pin returns high, `rd_en` stays low for 2 synchronizer cycles plus RECOVER_CYC cycles.
- R6: With `auto_en` high and the memory modified, `vsw_ok` falling makes the block pull the pin low. It checks after PROBE_CYC cycles that the pin really reads low, then runs grace and store. The pull lasts PROBE_CYC+GRACE_CYC+STORE_CYC cycles.
- R7: With `auto_en` high and the memory unmodified, `vsw_ok` falling gives a pull of exactly PROBE_CYC cycles and no transfer.
- R8: If the pin still reads high at the end of the probe window, the automatic store is abandoned after PROBE_CYC pull cycles. The modified mark is kept.
- R9: With `auto_en` low, `vsw_ok` falling causes no pull and no store.
- R10: While `vsw_ok` is low, write requests are refused and a low level on the request pin starts nothing.
- R11: A supply dip that keeps `vrst_ok` high causes no recall when `vsw_ok` returns. If `vrst_ok` went low during the dip, a full recall runs when `vsw_ok` returns.
- R12: A completed store or recall clears the modified mark, so a following request without writes performs no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsw_ok | input | 1 | Supply above switch level |
| vrst_ok | input | 1 | Supply above reset level |
| auto_en | input | 1 | Enables stores on power loss |
| req_pin_in | input | 1 | Level read from the shared active-low request pin |
| req_pull_low | output | 1 | Drives the shared pin low (open-drain busy) |
| wr_req | input | 1 | Host write request |
| wr_grant | output | 1 | Host write accepted this cycle |
| rd_en | output | 1 | Host reads allowed |
| xfer_en | output | 1 | One copy-port word transfer this cycle |
| xfer_to_nv | output | 1 | 1: working to shadow (store), 0: shadow to working (recall) |
| xfer_addr | output | ADDR_W | Copy-port word address |

## Verification
Requests are tried from three sources: the pin driven low from outside, a supply drop with power-loss stores enabled, and a supply drop with them disabled. Each source is tried with the memory modified and unmodified, which separates the dirty gating from the trigger path. A pin held high against the pull separates an abandoned store from a clean release. Dips with and without the reset comparator falling tell a brown-out apart from a real power cycle. Random write-request streams in the ready state confirm that grants follow requests one for one.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        NS_LOWV    = 3'd0,
        NS_RECALL  = 3'd1,
        NS_READY   = 3'd2,
        NS_PROBE   = 3'd3,
        NS_GRACE   = 3'd4,
        NS_STORE   = 3'd5,
        NS_HOLD    = 3'd6,
        NS_RECOVER = 3'd7
    } nvs_state_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic pull;
        logic copy;
        logic to_nv;
    } nvs_ctl_t;

    function automatic nvs_ctl_t ctl_of(input nvs_state_e s);
        nvs_ctl_t c;
        c = '0;
        case (s)
            NS_LOWV:    c.rd_ok = 1'b1;
            NS_RECALL:  c.copy  = 1'b1;
            NS_READY:   begin c.rd_ok = 1'b1; c.wr_ok = 1'b1; end
            NS_PROBE:   begin c.rd_ok = 1'b1; c.pull  = 1'b1; end
            NS_GRACE:   begin c.rd_ok = 1'b1; c.pull  = 1'b1; end
            NS_STORE:   begin c.pull  = 1'b1; c.copy  = 1'b1; c.to_nv = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d,
                                         input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
    parameter int unsigned STAGES = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvs_copy_seq.sv
module nvs_copy_seq #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic              active,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;
    logic              fin_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            addr_q <= '0;
            fin_q  <= 1'b0;
        end else if (!fin_q) begin
            if (addr_q == LAST) fin_q  <= 1'b1;
            else                addr_q <= addr_q + 1'b1;
        end
    end

    assign active = run && !fin_q;
    assign addr   = addr_q;
endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl
    import nvs_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned GRACE_CYC   = 8,
    parameter int unsigned STORE_CYC   = 40,
    parameter int unsigned RECALL_CYC  = 30,
    parameter int unsigned RECOVER_CYC = 6,
    parameter int unsigned PROBE_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsw_ok,
    input  logic              vrst_ok,
    input  logic              auto_en,
    input  logic              req_pin_in,
    output logic              req_pull_low,
    input  logic              wr_req,
    output logic              wr_grant,
    output logic              rd_en,
    output logic              xfer_en,
    output logic              xfer_to_nv,
    output logic [ADDR_W-1:0] xfer_addr
);
    localparam int unsigned MAX_DUR = max5(GRACE_CYC, STORE_CYC, RECALL_CYC,
                                           RECOVER_CYC, PROBE_CYC);
    localparam int unsigned TMR_W   = $clog2(MAX_DUR + 1);

    nvs_state_e        state_q, state_d;
    nvs_ctl_t          ctl;
    logic              pin_s;
    logic              tmr_zero, tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              dirty_q, recall_pend_q;
    logic              copy_active;
    logic [ADDR_W-1:0] copy_addr;

    nvs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst(rst), .d(req_pin_in), .q(pin_s)
    );

    nvs_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    nvs_copy_seq #(.ADDR_W(ADDR_W)) u_copy (
        .clk(clk), .rst(rst), .run(ctl.copy), .active(copy_active), .addr(copy_addr)
    );

    assign ctl = ctl_of(state_q);

    always_comb begin
        state_d = state_q;
        case (state_q)
            NS_LOWV:
                if (vsw_ok) state_d = recall_pend_q ? NS_RECALL : NS_READY;
            NS_RECALL:
                if (tmr_zero) state_d = vsw_ok ? NS_READY : NS_LOWV;
            NS_READY:
                if (!vsw_ok)     state_d = auto_en ? NS_PROBE : NS_LOWV;
                else if (!pin_s) state_d = dirty_q ? NS_GRACE : NS_HOLD;
            NS_PROBE:
                if (tmr_zero) state_d = (!pin_s && dirty_q) ? NS_GRACE : NS_LOWV;
            NS_GRACE:
                if (tmr_zero) state_d = NS_STORE;
            NS_STORE:
                if (tmr_zero) state_d = NS_HOLD;
            NS_HOLD:
                if (pin_s) state_d = NS_RECOVER;
            NS_RECOVER:
                if (tmr_zero) state_d = vsw_ok ? NS_READY : NS_LOWV;
            default:
                state_d = NS_LOWV;
        endcase
    end

    always_comb begin
        case (state_d)
            NS_RECALL:  tmr_val = TMR_W'(RECALL_CYC - 1);
            NS_PROBE:   tmr_val = TMR_W'(PROBE_CYC - 1);
            NS_GRACE:   tmr_val = TMR_W'(GRACE_CYC - 1);
            NS_STORE:   tmr_val = TMR_W'(STORE_CYC - 1);
            NS_RECOVER: tmr_val = TMR_W'(RECOVER_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) state_q <= NS_LOWV;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty_q       <= 1'b0;
            recall_pend_q <= 1'b1;
        end else begin
            if (wr_grant)
                dirty_q <= 1'b1;
            else if ((state_q == NS_STORE || state_q == NS_RECALL) && tmr_zero)
                dirty_q <= 1'b0;

            if (!vrst_ok)
                recall_pend_q <= 1'b1;
            else if (state_q == NS_RECALL && tmr_zero)
                recall_pend_q <= 1'b0;
        end
    end

    assign wr_grant     = wr_req && ctl.wr_ok && vsw_ok;
    assign rd_en        = ctl.rd_ok;
    assign req_pull_low = ctl.pull;
    assign xfer_en      = copy_active;
    assign xfer_to_nv   = ctl.to_nv;
    assign xfer_addr    = copy_addr;
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              vsw_ok,
    input logic              wr_grant,
    input logic              rd_en,
    input logic              req_pull_low,
    input logic              xfer_en,
    input logic              xfer_to_nv,
    input logic [ADDR_W-1:0] xfer_addr
);
    AST_XFER_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        xfer_en |-> (!rd_en && !wr_grant));                                  // R1

    AST_RECALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && !xfer_to_nv) |-> !req_pull_low);                         // R1

    AST_ADDR_START: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_en) |-> (xfer_addr == '0));                               // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && $past(xfer_en)) |-> (xfer_addr == ADDR_W'($past(xfer_addr) + 1'b1))); // R1

    AST_GRANT_READABLE: assert property (@(posedge clk) disable iff (rst)
        wr_grant |-> rd_en);                                                 // R2

    AST_STORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && xfer_to_nv) |-> req_pull_low);                           // R3

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (xfer_en && $past(xfer_en)) |-> $stable(xfer_to_nv));                // R3

    AST_LOWV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !vsw_ok |-> !wr_grant);                                              // R10
endmodule

bind nvstore_ctrl nvs_checker #(.ADDR_W(ADDR_W)) u_nvs_checker (
    .clk(clk), .rst(rst), .vsw_ok(vsw_ok), .wr_grant(wr_grant), .rd_en(rd_en),
    .req_pull_low(req_pull_low), .xfer_en(xfer_en), .xfer_to_nv(xfer_to_nv),
    .xfer_addr(xfer_addr)
);

// File: tb/test_nvstore_ctrl.sv
module test_nvstore_ctrl;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int GRACE = 8, STORE = 40, RECALL = 30, RECOVER = 6, PROBE = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic vsw_ok = 1'b1, vrst_ok = 1'b1, auto_en = 1'b0, wr_req = 1'b0;
    logic ext_low = 1'b0, hold_hi = 1'b0;
    logic req_pin_in, req_pull_low, wr_grant, rd_en, xfer_en, xfer_to_nv;
    logic [AW-1:0] xfer_addr;

    int n_total = 0, n_fail = 0;
    int n_pull = 0, n_xs = 0, n_xr = 0, n_rdoff = 0, n_addr_err = 0;
    int exp_addr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign req_pin_in = hold_hi ? 1'b1 : ~(req_pull_low | ext_low);

    nvstore_ctrl #(.ADDR_W(AW), .GRACE_CYC(GRACE), .STORE_CYC(STORE), .RECALL_CYC(RECALL),
                   .RECOVER_CYC(RECOVER), .PROBE_CYC(PROBE)) i_nvstore_ctrl (
        .clk(clk), .rst(rst), .vsw_ok(vsw_ok), .vrst_ok(vrst_ok), .auto_en(auto_en),
        .req_pin_in(req_pin_in), .req_pull_low(req_pull_low), .wr_req(wr_req),
        .wr_grant(wr_grant), .rd_en(rd_en), .xfer_en(xfer_en), .xfer_to_nv(xfer_to_nv),
        .xfer_addr(xfer_addr)
    );

    always @(negedge clk) if (!rst) begin
        if (req_pull_low) n_pull++;
        if (!rd_en) n_rdoff++;
        if (xfer_en) begin
            if (xfer_to_nv) n_xs++; else n_xr++;
            if (int'(xfer_addr) != exp_addr) n_addr_err++;
            exp_addr = int'(xfer_addr) + 1;
        end else exp_addr = 0;
    end

    function automatic int exp_pull_auto(input bit dirty, input bit blocked);
        return (dirty && !blocked) ? PROBE + GRACE + STORE : PROBE;
    endfunction
    function automatic int exp_pull_pin(input bit dirty);
        return dirty ? GRACE + STORE : 0;
    endfunction

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write();
        wr_req = 1'b1; tick(); wr_req = 1'b0;
    endtask

    task automatic release_and_wait();
        ext_low = 1'b0; tick(3 + RECOVER + 2);
    endtask

    int p0, xs0, xr0, r0;
    task automatic snap();
        p0 = n_pull; xs0 = n_xs; xr0 = n_xr; r0 = n_rdoff;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int k, bad;
        void'($urandom(32'd20240611));
        // reset state
        wr_req = 1'b1;
        tick(3);
        check("R2 reset grant", int'(wr_grant), 0);
        check("R1 reset pull", int'(req_pull_low), 0);
        check("R1 reset xfer", int'(xfer_en), 0);
        wr_req = 1'b0;
        // R1 power-up recall
        snap(); rst = 1'b0;
        tick(RECALL + 5);
        check("R1 recall words", n_xr - xr0, DEPTH);
        check("R1 recall access off", n_rdoff - r0, RECALL);
        check("R1 recall pull", n_pull - p0, 0);
        check("R1 recall addr order", n_addr_err, 0);
        // R2 random writes
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            wr_req = ($urandom % 2) == 1 || i == 39;
            #0.5;
            if (wr_grant != wr_req) bad++;
            tick();
        end
        wr_req = 1'b0;
        check("R2 grant follows request", bad, 0);
        // R3 pin store with dirty, R5 hold/recovery
        snap(); ext_low = 1'b1;
        tick(4);
        wr_req = 1'b1; #0.5;
        check("R3 grace write refused", int'(wr_grant), 0);
        check("R3 grace read enabled", int'(rd_en), 1);
        wr_req = 1'b0;
        tick(GRACE + STORE + 10);
        check("R3 store words", n_xs - xs0, DEPTH);
        check("R3 pull length", n_pull - p0, exp_pull_pin(1'b1));
        check("R5 held while pin low", int'(rd_en), 0);
        ext_low = 1'b0; k = 0;
        for (int i = 0; i < 50 && !rd_en; i++) begin tick(); if (!rd_en) k++; end
        check("R5 recovery cycles", k, 2 + RECOVER);
        // R4 / R12 clean pin request after store
        snap(); ext_low = 1'b1; tick(20);
        check("R4 R12 no store when clean", n_xs - xs0, 0);
        check("R4 no pull when clean", n_pull - p0, exp_pull_pin(1'b0));
        check("R4 access held", int'(rd_en), 0);
        release_and_wait();
        // R6 auto store with dirty
        auto_en = 1'b1; tick(2); do_write(); tick(2);
        snap(); vsw_ok = 1'b0;
        tick(PROBE + GRACE + STORE + 20);
        check("R6 auto pull length", n_pull - p0, exp_pull_auto(1'b1, 1'b0));
        check("R6 auto store words", n_xs - xs0, DEPTH);
        wr_req = 1'b1; #0.5;
        check("R10 write refused low supply", int'(wr_grant), 0);
        wr_req = 1'b0;
        snap(); vsw_ok = 1'b1; tick(10);
        check("R11 brown-out no recall", n_xr - xr0, 0);
        // R7 auto clean
        snap(); vsw_ok = 1'b0; tick(PROBE + 20);
        check("R7 clean pull length", n_pull - p0, exp_pull_auto(1'b0, 1'b0));
        check("R7 clean no store", n_xs - xs0, 0);
        vsw_ok = 1'b1; tick(5);
        // R8 abort when pin held high
        do_write(); tick(2);
        snap(); hold_hi = 1'b1; vsw_ok = 1'b0; tick(PROBE + 20);
        check("R8 abort pull length", n_pull - p0, exp_pull_auto(1'b1, 1'b1));
        check("R8 abort no store", n_xs - xs0, 0);
        vsw_ok = 1'b1; hold_hi = 1'b0; tick(5);
        snap(); ext_low = 1'b1; tick(GRACE + STORE + 10);
        check("R8 dirty kept after abort", n_xs - xs0, DEPTH);
        release_and_wait();
        // R9 / R10 auto disabled
        auto_en = 1'b0; do_write(); tick(2);
        snap(); vsw_ok = 1'b0; tick(PROBE + GRACE + STORE + 10);
        check("R9 no pull auto off", n_pull - p0, 0);
        check("R9 no store auto off", n_xs - xs0, 0);
        ext_low = 1'b1; tick(20);
        check("R10 pin ignored low supply", n_pull - p0 + n_xs - xs0, 0);
        ext_low = 1'b0; tick(4);
        // R11 / R12 deep drop recall clears dirty
        vrst_ok = 1'b0; tick(5); vrst_ok = 1'b1; tick(2);
        snap(); vsw_ok = 1'b1; tick(RECALL + 5);
        check("R11 recall after reset-level drop", n_xr - xr0, DEPTH);
        snap(); ext_low = 1'b1; tick(20);
        check("R12 recall cleared dirty", n_xs - xs0, 0);
        release_and_wait();
        check("R1 transfer addr order overall", n_addr_err, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule